// File: doc/BRIEF.md
# Interrupt Status Collector

This block gathers condition signals from a group of subsystems into one read-only status word and a matching set of latched interrupt bits. The subsystems are a script-task engine, a register upload engine, an external bus controller, an I2C master, four audio DMA channels with their FIFOs and three video DMA channels with their FIFOs. Some status bits are sticky error flags. A sticky error flag is cleared only when its own subsystem starts a new operation. Other status bits are busy levels or FIFO and protection conditions that are captured every cycle.

Each interrupt bit latches on an edge of its status bit. For the three busy indicators the edge is the falling one, so the interrupt marks completion. For every other bit the edge is the rising one, so the interrupt marks a new condition. Software clears an interrupt bit by writing a one to it. A mask register gates the single interrupt request output.

Top module: `irq_status_collector`

## Requirements
- R1: After reset the status word is 0x0004_0000, with only bit 18 set. The interrupt bits, the mask and the interrupt request are all zero.
- R2: Status bit 21 sets the cycle after a `task0_tmo` pulse and clears the cycle after `task0_start`. When both inputs are high in the same cycle, the bit ends up set.
- R3: Status bits 20, 19 and 17 each show `upload_busy`, `xbus_busy` and `i2c_busy` respectively, delayed by one clock.
- R4: The interrupt bits 20, 19 and 17 latch only on a falling edge of their status bit. They become visible one clock after the status bit falls. A rising edge of these status bits latches nothing.
- R5: Status bit 18 is the OR of two sticky flags, one set by `xbus_evt` and one set by `xbus_tmo`. The timeout flag resets to 1. Both flags clear on `xbus_start`. The reset value of bit 18 never produces an interrupt.
- R6: Status bit 16 sets the cycle after any bit of `i2c_err` is high and clears the cycle after `i2c_start`.
- R7: Status bits 12 to 15 are sticky address protection flags. `aud_prot[i]` sets bit 12+i, where index 0 is channel 1 output, 1 is channel 1 input, 2 is channel 2 output and 3 is channel 2 input. Each bit is cleared only by `aud_start` of the same index.
- R8: Status bit 11 is the registered OR of `aud_fifo_err`. Status bit 9 is the registered OR of `vid_fifo_err`. Status bit 10 is the registered OR of `vid_prot & vid_active`, so a protection error on an inactive video channel is ignored.
- R9: Interrupt bits 21, 18, 16 and 15 to 9 latch on a rising edge of their status bit. They become visible one clock after the status bit rises.
- R10: A `clr_wr_en` cycle clears every interrupt bit whose `clr_wdata` bit is 1 and leaves the others unchanged. When a latch event and a clear hit the same bit in the same cycle, the bit is set.
- R11: `irq_req` is high exactly when some interrupt bit and its mask bit are both 1. The mask is loaded from `mask_wdata` on `mask_wr_en`. Bits 31 to 22 and 8 to 0 of the status word, the interrupt bits and the mask always read zero.
- R12: Software clear writes never change the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task0_tmo | input | 1 | Script task 0 wait-state overrun pulse |
| task0_start | input | 1 | Script task 0 start strobe |
| upload_busy | input | 1 | Register upload in progress |
| xbus_busy | input | 1 | External bus transfer active or halted |
| xbus_evt | input | 1 | External bus event pulse |
| xbus_tmo | input | 1 | External bus timeout pulse |
| xbus_start | input | 1 | External bus command start strobe |
| i2c_busy | input | 1 | I2C transfer active or halted |
| i2c_err | input | I2C_ERR_W | I2C error conditions |
| i2c_start | input | 1 | I2C transfer start strobe |
| aud_prot | input | 4 | Audio DMA address protection hits |
| aud_start | input | 4 | Audio DMA channel start strobes |
| aud_fifo_err | input | 4 | Audio FIFO overflow or underflow |
| vid_prot | input | 3 | Video DMA address protection errors |
| vid_active | input | 3 | Video DMA transfer active |
| vid_fifo_err | input | 3 | Video FIFO overflow or underflow |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wdata | input | 32 | Mask write data |
| clr_wr_en | input | 1 | Interrupt clear write strobe |
| clr_wdata | input | 32 | Write-one-to-clear data |
| status_word | output | 32 | Primary status word |
| irq_status | output | 32 | Latched interrupt bits |
| irq_mask | output | 32 | Current mask |
| irq_req | output | 1 | Masked interrupt request |

## Verification
The busy inputs are driven as a rise followed by a fall. This separates falling-edge latching from rising-edge latching: a wrong edge shows up as an interrupt one step early, or as no interrupt at all. Several kinds of pulse are applied to the sticky flags:
- a set pulse alone;
- a set pulse and a start in the same cycle;
- a start belonging to a neighbouring channel;
- a software clear.

Together these show which source may clear each flag and which source wins when two arrive together. The video protection input is applied with its channel active and with it inactive. A clear write whose data is zero is applied to show that zero bits are left unchanged. A clear is also aligned with a pending rising edge to check that the set wins.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int STAT_W  = 32;
  localparam int AUD_CH  = 4;
  localparam int VID_CH  = 3;
  localparam int BIT_LO  = 9;
  localparam int BIT_HI  = 21;

  localparam int B_T0_TMO   = 21;
  localparam int B_UPLD     = 20;
  localparam int B_XBUS_BSY = 19;
  localparam int B_XBUS_EVT = 18;
  localparam int B_I2C_BSY  = 17;
  localparam int B_I2C_ERR  = 16;
  localparam int B_AUD_LO   = 12;
  localparam int B_AFIFO    = 11;
  localparam int B_VPROT    = 10;
  localparam int B_VFIFO    = 9;

  // Bits whose interrupt marks completion (falling edge).
  function automatic bit is_busy_bit(int b);
    return (b == B_UPLD) || (b == B_XBUS_BSY) || (b == B_I2C_BSY);
  endfunction

  // Reset value of each status bit.
  function automatic bit stat_rst_val(int b);
    return (b == B_XBUS_EVT);
  endfunction
endpackage

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;          // set has priority over start-clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= RST_VAL;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter bit FALL_EDGE = 1'b0,
  parameter bit RST_VAL   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_i,
  input  logic clr_i,
  output logic irq_o
);
  logic prev_q, irq_q, irq_d, irq_en, evt;

  always_comb begin
    evt    = FALL_EDGE ? (prev_q & ~stat_i) : (~prev_q & stat_i);
    irq_en = evt | clr_i;
    irq_d  = evt;             // event wins over software clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= RST_VAL;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= stat_i;
      if (irq_en) irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_collector.sv
module irq_status_collector
  import irq_stat_pkg::*;
#(
  parameter int I2C_ERR_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 task0_tmo,
  input  logic                 task0_start,
  input  logic                 upload_busy,
  input  logic                 xbus_busy,
  input  logic                 xbus_evt,
  input  logic                 xbus_tmo,
  input  logic                 xbus_start,
  input  logic                 i2c_busy,
  input  logic [I2C_ERR_W-1:0] i2c_err,
  input  logic                 i2c_start,
  input  logic [AUD_CH-1:0]    aud_prot,
  input  logic [AUD_CH-1:0]    aud_start,
  input  logic [AUD_CH-1:0]    aud_fifo_err,
  input  logic [VID_CH-1:0]    vid_prot,
  input  logic [VID_CH-1:0]    vid_active,
  input  logic [VID_CH-1:0]    vid_fifo_err,
  input  logic                 mask_wr_en,
  input  logic [STAT_W-1:0]    mask_wdata,
  input  logic                 clr_wr_en,
  input  logic [STAT_W-1:0]    clr_wdata,
  output logic [STAT_W-1:0]    status_word,
  output logic [STAT_W-1:0]    irq_status,
  output logic                 irq_req,
  output logic [STAT_W-1:0]    irq_mask
);
  localparam logic [STAT_W-1:0] USED_MASK =
    ({STAT_W{1'b1}} >> (STAT_W - 1 - BIT_HI)) & ({STAT_W{1'b1}} << BIT_LO);

  // Sticky flags
  logic t0_tmo_q, xevt_q, xtmo_q, i2c_err_q;
  logic [AUD_CH-1:0] aud_prot_q;

  irq_sticky_flag #(.RST_VAL(1'b0)) u_t0_tmo (
    .clk(clk), .rst_n(rst_n), .set_i(task0_tmo), .clr_i(task0_start), .flag_o(t0_tmo_q));
  irq_sticky_flag #(.RST_VAL(1'b0)) u_xbus_evt (
    .clk(clk), .rst_n(rst_n), .set_i(xbus_evt), .clr_i(xbus_start), .flag_o(xevt_q));
  irq_sticky_flag #(.RST_VAL(1'b1)) u_xbus_tmo (
    .clk(clk), .rst_n(rst_n), .set_i(xbus_tmo), .clr_i(xbus_start), .flag_o(xtmo_q));
  irq_sticky_flag #(.RST_VAL(1'b0)) u_i2c_err (
    .clk(clk), .rst_n(rst_n), .set_i(|i2c_err), .clr_i(i2c_start), .flag_o(i2c_err_q));

  for (genvar c = 0; c < AUD_CH; c++) begin : g_aud
    irq_sticky_flag #(.RST_VAL(1'b0)) u_prot (
      .clk(clk), .rst_n(rst_n), .set_i(aud_prot[c]), .clr_i(aud_start[c]),
      .flag_o(aud_prot_q[c]));
  end

  // Level captures
  typedef struct packed {
    logic upld;
    logic xbsy;
    logic ibsy;
    logic afifo;
    logic vprot;
    logic vfifo;
  } lvl_t;

  lvl_t lvl_d, lvl_q;

  always_comb begin
    lvl_d.upld  = upload_busy;
    lvl_d.xbsy  = xbus_busy;
    lvl_d.ibsy  = i2c_busy;
    lvl_d.afifo = |aud_fifo_err;
    lvl_d.vprot = |(vid_prot & vid_active);
    lvl_d.vfifo = |vid_fifo_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  // Status word assembly
  logic [STAT_W-1:0] stat_vec;
  always_comb begin
    stat_vec                        = '0;
    stat_vec[B_T0_TMO]              = t0_tmo_q;
    stat_vec[B_UPLD]                = lvl_q.upld;
    stat_vec[B_XBUS_BSY]            = lvl_q.xbsy;
    stat_vec[B_XBUS_EVT]            = xevt_q | xtmo_q;
    stat_vec[B_I2C_BSY]             = lvl_q.ibsy;
    stat_vec[B_I2C_ERR]             = i2c_err_q;
    stat_vec[B_AUD_LO +: AUD_CH]    = aud_prot_q;
    stat_vec[B_AFIFO]               = lvl_q.afifo;
    stat_vec[B_VPROT]               = lvl_q.vprot;
    stat_vec[B_VFIFO]               = lvl_q.vfifo;
  end

  // Interrupt latches
  logic [STAT_W-1:0] clr_vec, irq_vec;
  assign clr_vec = clr_wr_en ? (clr_wdata & USED_MASK) : '0;

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (b >= BIT_LO && b <= BIT_HI) begin : g_used
      irq_edge_latch #(
        .FALL_EDGE(is_busy_bit(b)),
        .RST_VAL  (stat_rst_val(b))
      ) u_latch (
        .clk(clk), .rst_n(rst_n), .stat_i(stat_vec[b]), .clr_i(clr_vec[b]),
        .irq_o(irq_vec[b]));
    end else begin : g_unused
      assign irq_vec[b] = 1'b0;
    end
  end

  // Mask register
  logic [STAT_W-1:0] mask_q, mask_d;
  assign mask_d = mask_wdata & USED_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mask_q <= '0;
    else if (mask_wr_en) mask_q <= mask_d;
  end

  logic unused_wbits;
  assign unused_wbits = ^(clr_wdata & ~USED_MASK) ^ ^(mask_wdata & ~USED_MASK);

  assign status_word = stat_vec;
  assign irq_status  = irq_vec;
  assign irq_mask    = mask_q;
  assign irq_req     = |(irq_vec & mask_q);
endmodule

// File: rtl/irq_status_checker.sv
module irq_status_checker (
  input logic clk,
  input logic rst_n,
  input logic task0_tmo,
  input logic task0_start,
  input logic xbus_busy,
  input logic aud_prot0,
  input logic aud_start0,
  input logic clr_wr_en,
  input logic st21,
  input logic st19,
  input logic st12,
  input logic irq19,
  input logic any_irq,
  input logic irq_req
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_tmo_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    task0_start && !task0_tmo |=> !st21);

  p_busy_follow_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    st19 == $past(xbus_busy));

  p_fall_latch_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $fell(st19) |=> irq19);

  p_aud_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    aud_start0 && !aud_prot0 |=> !st12);

  p_req_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !any_irq |-> !irq_req);

  p_sticky_sw_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_en && st21 && !task0_start |=> st21);
endmodule

bind irq_status_collector irq_status_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .task0_tmo  (task0_tmo),
  .task0_start(task0_start),
  .xbus_busy  (xbus_busy),
  .aud_prot0  (aud_prot[0]),
  .aud_start0 (aud_start[0]),
  .clr_wr_en  (clr_wr_en),
  .st21       (status_word[21]),
  .st19       (status_word[19]),
  .st12       (status_word[12]),
  .irq19      (irq_status[19]),
  .any_irq    (|irq_status),
  .irq_req    (irq_req)
);

// File: tb/irq_status_collector_tb_top.sv
module irq_status_collector_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic task0_tmo, task0_start, upload_busy, xbus_busy, xbus_evt, xbus_tmo, xbus_start;
  logic i2c_busy, i2c_start;
  logic [2:0] i2c_err;
  logic [3:0] aud_prot, aud_start, aud_fifo_err;
  logic [2:0] vid_prot, vid_active, vid_fifo_err;
  logic mask_wr_en, clr_wr_en;
  logic [31:0] mask_wdata, clr_wdata;
  logic [31:0] status_word, irq_status, irq_mask;
  logic irq_req;

  always #2.5 clk = ~clk;

  irq_status_collector dut_i (
    .clk(clk), .rst_n(rst_n), .task0_tmo(task0_tmo), .task0_start(task0_start),
    .upload_busy(upload_busy), .xbus_busy(xbus_busy), .xbus_evt(xbus_evt),
    .xbus_tmo(xbus_tmo), .xbus_start(xbus_start), .i2c_busy(i2c_busy),
    .i2c_err(i2c_err), .i2c_start(i2c_start), .aud_prot(aud_prot),
    .aud_start(aud_start), .aud_fifo_err(aud_fifo_err), .vid_prot(vid_prot),
    .vid_active(vid_active), .vid_fifo_err(vid_fifo_err), .mask_wr_en(mask_wr_en),
    .mask_wdata(mask_wdata), .clr_wr_en(clr_wr_en), .clr_wdata(clr_wdata),
    .status_word(status_word), .irq_status(irq_status), .irq_req(irq_req),
    .irq_mask(irq_mask));

  typedef struct {
    string       tag;
    logic [31:0] st;
    logic [31:0] irq;
    logic [31:0] msk;
    logic        req;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [31:0] exp_st, exp_irq, exp_msk;

  function automatic logic [31:0] bm(int b);
    return 32'h1 << b;
  endfunction

  task automatic push(string tag);
    item_t it;
    it.tag = tag; it.st = exp_st; it.irq = exp_irq; it.msk = exp_msk;
    it.req = |(exp_irq & exp_msk);
    exp_q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_all();
    clr_wr_en = 1'b1; clr_wdata = 32'hFFFF_FFFF;
    step();
    clr_wr_en = 1'b0; clr_wdata = '0;
    exp_irq = '0;
  endtask

  // Monitor: pops expectations and compares against outputs
  initial begin
    forever begin
      item_t it;
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      n_chk++;
      if (status_word !== it.st || irq_status !== it.irq || irq_mask !== it.msk ||
          irq_req !== it.req) begin
        n_err++;
        $display("FAIL %s: status=%h/%h irq=%h/%h mask=%h/%h req=%b/%b (actual/expected)",
                 it.tag, status_word, it.st, irq_status, it.irq, irq_mask, it.msk,
                 irq_req, it.req);
      end
    end
  end

  task automatic busy_test(int b);
    case (b)
      20: upload_busy = 1'b1;
      19: xbus_busy = 1'b1;
      default: i2c_busy = 1'b1;
    endcase
    step(); exp_st |= bm(b); push("R3 busy level follows");
    step(); push("R4 no latch on rise");
    upload_busy = 1'b0; xbus_busy = 1'b0; i2c_busy = 1'b0;
    step(); exp_st &= ~bm(b); push("R3 busy drop follows");
    step(); exp_irq |= bm(b); push("R4 falling edge latch");
  endtask

  // Driver
  initial begin
    rst_n = 1'b0;
    {task0_tmo, task0_start, upload_busy, xbus_busy, xbus_evt, xbus_tmo, xbus_start} = '0;
    {i2c_busy, i2c_start, i2c_err} = '0;
    {aud_prot, aud_start, aud_fifo_err, vid_prot, vid_active, vid_fifo_err} = '0;
    {mask_wr_en, clr_wr_en, mask_wdata, clr_wdata} = '0;
    repeat (3) step();
    rst_n = 1'b1;
    exp_st = bm(18); exp_irq = '0; exp_msk = '0;
    push("R1 reset state");
    step(); step(); push("R5 no false edge after reset");

    // R5 external bus event flag
    xbus_start = 1'b1; step(); xbus_start = 1'b0;
    exp_st = '0; push("R5 start clears reset timeout");
    step(); push("R9 fall of bit18 latches nothing");
    xbus_tmo = 1'b1; step(); xbus_tmo = 1'b0;
    exp_st |= bm(18); push("R5 timeout sets");
    step(); exp_irq |= bm(18); push("R9 rising edge latch");
    xbus_start = 1'b1; step(); xbus_start = 1'b0;
    exp_st = '0; push("R5 start clears");
    xbus_evt = 1'b1; step(); xbus_evt = 1'b0;
    exp_st |= bm(18); push("R5 event flag sets");
    xbus_start = 1'b1; step(); xbus_start = 1'b0;
    exp_st = '0; push("R5 start clears event");

    // R10 write-one-to-clear
    clr_wr_en = 1'b1; clr_wdata = 32'h0; step(); clr_wr_en = 1'b0;
    push("R10 zero write keeps");
    clr_wr_en = 1'b1; clr_wdata = bm(18); step(); clr_wr_en = 1'b0; clr_wdata = '0;
    exp_irq = '0; push("R10 one clears");

    // R11 mask and request, R2, R12
    mask_wr_en = 1'b1; mask_wdata = 32'hFFFF_FFFF; step(); mask_wr_en = 1'b0;
    exp_msk = 32'h003F_FE00; push("R11 mask keeps used bits only");
    mask_wr_en = 1'b1; mask_wdata = bm(21); step(); mask_wr_en = 1'b0;
    exp_msk = bm(21); push("R11 mask load");
    task0_tmo = 1'b1; step(); task0_tmo = 1'b0;
    exp_st |= bm(21); push("R2 timeout sets");
    step(); exp_irq |= bm(21); push("R11 request raised");
    clear_all(); push("R12 sticky survives clear");
    task0_start = 1'b1; step(); task0_start = 1'b0;
    exp_st &= ~bm(21); push("R2 start clears");
    task0_tmo = 1'b1; task0_start = 1'b1; step(); task0_tmo = 1'b0; task0_start = 1'b0;
    exp_st |= bm(21); push("R2 set wins over start");
    step(); exp_irq |= bm(21); push("R9 bit21 latched");
    task0_start = 1'b1; step(); task0_start = 1'b0;
    exp_st &= ~bm(21); push("R2 cleared again");
    clear_all(); push("R11 request dropped");

    // R3 and R4 busy bits
    busy_test(20);
    busy_test(19);
    busy_test(17);
    clear_all(); push("R10 clear all busy irqs");

    // R6 I2C error
    i2c_err = 3'b100; step(); i2c_err = '0;
    exp_st |= bm(16); push("R6 error sets");
    step(); exp_irq |= bm(16); push("R9 bit16 latched");
    i2c_start = 1'b1; step(); i2c_start = 1'b0;
    exp_st &= ~bm(16); push("R6 start clears");
    clear_all();

    // R10 set beats clear
    i2c_err = 3'b001; step(); i2c_err = '0;
    exp_st |= bm(16); push("R6 error sets again");
    clr_wr_en = 1'b1; clr_wdata = bm(16); step(); clr_wr_en = 1'b0; clr_wdata = '0;
    exp_irq |= bm(16); push("R10 set wins over clear");
    i2c_start = 1'b1; step(); i2c_start = 1'b0;
    exp_st &= ~bm(16);
    clear_all(); push("R6 idle after clear");

    // R7 audio protection
    aud_prot = 4'b1000; step(); aud_prot = '0;
    exp_st |= bm(15); push("R7 channel 3 maps to bit15");
    step(); exp_irq |= bm(15); push("R9 bit15 latched");
    aud_start = 4'b0001; step(); aud_start = '0;
    push("R7 other channel start ignored");
    aud_start = 4'b1000; step(); aud_start = '0;
    exp_st &= ~bm(15); push("R7 own start clears");
    aud_prot = 4'b0001; step(); aud_prot = '0;
    exp_st |= bm(12); push("R7 channel 0 maps to bit12");
    aud_start = 4'b0001; step(); aud_start = '0;
    exp_st &= ~bm(12); exp_irq |= bm(12); push("R7 bit12 cleared, irq kept");
    clear_all();

    // R8 FIFO and video protection
    aud_fifo_err = 4'b0100; step();
    exp_st |= bm(11); push("R8 audio fifo error");
    step(); exp_irq |= bm(11); push("R9 bit11 latched");
    aud_fifo_err = '0; step();
    exp_st &= ~bm(11); push("R8 audio fifo level drops");
    vid_prot = 3'b010; vid_active = 3'b000; step();
    push("R8 inactive video protection ignored");
    step(); push("R8 still ignored");
    vid_active = 3'b010; step();
    exp_st |= bm(10); push("R8 active video protection");
    vid_prot = '0; vid_active = '0; step();
    exp_st &= ~bm(10); exp_irq |= bm(10); push("R9 bit10 latched");
    vid_fifo_err = 3'b001; step(); vid_fifo_err = '0;
    exp_st |= bm(9); push("R8 video fifo error");
    step(); exp_st &= ~bm(9); exp_irq |= bm(9); push("R9 bit9 latched");
    clear_all(); push("R10 final clear");

    wait (exp_q.size() == 0);
    step();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule